// File: doc/BRIEF.md
# Round-Robin Context Issue Selector

This block feeds a shared, instruction-interleaved pipeline. On every clock cycle it picks one of several hardware processor contexts and issues it. Sixteen contexts is the default. The selector keeps a program counter and two status flags for each context. A context is eligible when it has no instruction in the pipeline and is not suspended. The search starts at the context after the one issued last and wraps around.

When an instruction finishes, the pipeline writes the next PC back for its context, and that context becomes eligible again. Each context therefore has at most one instruction in flight, and the pipeline never needs forwarding or stall logic.

Long-latency events park a context while the others keep issuing. Examples are a cache miss, or an unimplemented instruction handed off to an external service processor. A separate resume strobe releases a parked context. When no context is eligible, the selector issues a bubble.

Top module: `ctx_issue_sel`

## Requirements
- R1: While `rst` is high, `iss_vld` is low. After reset, every context is eligible and context i holds the PC slice `rst_pc_vec[i*PC_W +: PC_W]`. The first issue after reset is context 0.
- R2: The search for the next context starts at the context after the last one issued and wraps from NUM_CTX-1 to 0. A bubble leaves the starting point unchanged.
- R3: The issue outputs are registered. A context that is eligible before a clock edge appears on `iss_ctx`/`iss_pc` with `iss_vld` high right after that edge.
- R4: An issued context is not issued again until a writeback for it has been accepted. Two consecutive valid issues never carry the same context.
- R5: A writeback (`wb_vld`, `wb_ctx`) to a context with an instruction in flight stores `wb_pc` as that context's PC. The context becomes eligible from the next cycle, and its next issue carries `wb_pc`.
- R6: A writeback to a context with no instruction in flight is ignored, and that context's PC is unchanged.
- R7: `susp_vld` with `susp_ctx` parks a context: it is not issued until it is resumed, while the other contexts keep issuing. A writeback to a parked context with an instruction in flight is still accepted.
- R8: When the same context receives a suspend and a resume in the same cycle, the resume wins and the context is not parked.
- R9: When no context is eligible, `iss_vld`, `iss_ctx` and `iss_pc` are all zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pc_vec | input | NUM_CTX*PC_W | Reset PC of every context; context i uses bits i*PC_W upward |
| wb_vld | input | 1 | Next-PC writeback strobe |
| wb_ctx | input | CTX_W | Context of the writeback |
| wb_pc | input | PC_W | Next PC written back |
| susp_vld | input | 1 | Suspend strobe |
| susp_ctx | input | CTX_W | Context to park |
| resm_vld | input | 1 | Resume strobe |
| resm_ctx | input | CTX_W | Context to release |
| iss_vld | output | 1 | Issue slot holds a context (low means bubble) |
| iss_ctx | output | CTX_W | Issued context ID |
| iss_pc | output | PC_W | PC of the issued context |

## Verification
All strobes take effect at the clock edge that samples them. The choice made at an edge uses only the state from before that edge, so a writeback or resume shows up on the issue port two edges after it is driven, and an eligible context shows up one edge later.

The bench drives its inputs on the falling edge. A reference model updates on the rising edge with the same one-edge rule, and every output is compared on the next falling edge. Directed cases count edges explicitly for each of these events: the first issue after reset, the end of the first round, a writeback, a suspend, an ignored writeback, and a simultaneous suspend and resume.

// File: rtl/ctx_sel_pkg.sv
package ctx_sel_pkg;

    localparam int DEF_NUM_CTX = 16;
    localparam int DEF_PC_W    = 32;

    // Per-context status flags
    typedef struct packed {
        logic busy;    // an instruction of this context is in flight
        logic parked;  // held out by a long-latency event
    } slot_stat_t;

    // Wrap an index that may have run past the last context
    function automatic int ctx_wrap(input int v, input int n);
        return (v >= n) ? v - n : v;
    endfunction

endpackage

// File: rtl/ctx_onehot_dec.sv
module ctx_onehot_dec #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] hot
);
    always_comb begin
        hot = '0;
        for (int i = 0; i < N; i++) begin
            if (en && (int'(idx) == i)) hot[i] = 1'b1;
        end
    end
endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick
    import ctx_sel_pkg::*;
#(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] elig,
    input  logic [W-1:0] last,
    output logic         found,
    output logic [W-1:0] pick
);
    // Scan from the entry after the last winner; first eligible entry wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int off = 1; off <= N; off++) begin
            if (!found && elig[ctx_wrap(int'(last) + off, N)]) begin
                found = 1'b1;
                pick  = W'(ctx_wrap(int'(last) + off, N));
            end
        end
    end
endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
    import ctx_sel_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] rst_pc,
    input  logic            iss_hit,
    input  logic            wb_hit,
    input  logic [PC_W-1:0] wb_pc,
    input  logic            susp_hit,
    input  logic            resm_hit,
    output logic [PC_W-1:0] pc,
    output logic            ready
);
    slot_stat_t st;
    logic       wb_take;

    assign wb_take = wb_hit && st.busy;
    assign ready   = !st.busy && !st.parked;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
            pc <= rst_pc;
        end else begin
            if (iss_hit)      st.busy <= 1'b1;
            else if (wb_take) st.busy <= 1'b0;

            if (wb_take) pc <= wb_pc;

            if (resm_hit)      st.parked <= 1'b0;
            else if (susp_hit) st.parked <= 1'b1;
        end
    end

    // R4: the picker only selects a slot with nothing in flight
    a_r4_issue_idle_only: assert property (@(posedge clk) disable iff (rst)
        iss_hit |-> !st.busy);

    // R4: in-flight state persists until a writeback arrives
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !wb_hit) |=> st.busy);

    // R6: the PC moves only on an accepted writeback
    a_r6_pc_stable: assert property (@(posedge clk) disable iff (rst)
        !(wb_hit && st.busy) |=> $stable(pc));

    // R7: a parked slot stays parked until resumed
    a_r7_parked_holds: assert property (@(posedge clk) disable iff (rst)
        (st.parked && !resm_hit) |=> st.parked);

    // R8: a resume always leaves the slot unparked
    a_r8_resume_wins: assert property (@(posedge clk) disable iff (rst)
        resm_hit |=> !st.parked);
endmodule

// File: rtl/ctx_issue_sel.sv
module ctx_issue_sel
    import ctx_sel_pkg::*;
#(
    parameter int NUM_CTX = DEF_NUM_CTX,
    parameter int PC_W    = DEF_PC_W,
    localparam int CTX_W  = $clog2(NUM_CTX)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CTX*PC_W-1:0] rst_pc_vec,
    input  logic                    wb_vld,
    input  logic [CTX_W-1:0]        wb_ctx,
    input  logic [PC_W-1:0]         wb_pc,
    input  logic                    susp_vld,
    input  logic [CTX_W-1:0]        susp_ctx,
    input  logic                    resm_vld,
    input  logic [CTX_W-1:0]        resm_ctx,
    output logic                    iss_vld,
    output logic [CTX_W-1:0]        iss_ctx,
    output logic [PC_W-1:0]         iss_pc
);
    logic [NUM_CTX-1:0] wb_hit, susp_hit, resm_hit, iss_hit, elig;
    logic [PC_W-1:0]    slot_pc [NUM_CTX];
    logic               found;
    logic [CTX_W-1:0]   pick, last;

    ctx_onehot_dec #(.N(NUM_CTX)) u_dec_wb   (.en(wb_vld),   .idx(wb_ctx),   .hot(wb_hit));
    ctx_onehot_dec #(.N(NUM_CTX)) u_dec_susp (.en(susp_vld), .idx(susp_ctx), .hot(susp_hit));
    ctx_onehot_dec #(.N(NUM_CTX)) u_dec_resm (.en(resm_vld), .idx(resm_ctx), .hot(resm_hit));
    ctx_onehot_dec #(.N(NUM_CTX)) u_dec_iss  (.en(found),    .idx(pick),     .hot(iss_hit));

    ctx_rr_pick #(.N(NUM_CTX)) u_pick (
        .elig  (elig),
        .last  (last),
        .found (found),
        .pick  (pick)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
        ctx_slot #(.PC_W(PC_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .rst_pc   (rst_pc_vec[g*PC_W +: PC_W]),
            .iss_hit  (iss_hit[g]),
            .wb_hit   (wb_hit[g]),
            .wb_pc    (wb_pc),
            .susp_hit (susp_hit[g]),
            .resm_hit (resm_hit[g]),
            .pc       (slot_pc[g]),
            .ready    (elig[g])
        );
    end

    // Registered issue port and round-robin pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            iss_vld <= 1'b0;
            iss_ctx <= '0;
            iss_pc  <= '0;
            last    <= CTX_W'(NUM_CTX - 1);
        end else begin
            iss_vld <= found;
            iss_ctx <= found ? pick : '0;
            iss_pc  <= found ? slot_pc[pick] : '0;
            if (found) last <= pick;
        end
    end

    // R2: the winner is always an eligible context
    a_r2_pick_eligible: assert property (@(posedge clk) disable iff (rst)
        found |-> elig[pick]);

    // R2: a bubble is chosen only when nothing is eligible
    a_r2_no_missed_ctx: assert property (@(posedge clk) disable iff (rst)
        (elig != '0) |-> found);

    // R4: never the same context in two back-to-back slots
    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && $past(iss_vld)) |-> (iss_ctx != $past(iss_ctx)));

    // R9: nothing eligible gives an all-zero slot next cycle
    a_r9_bubble_zero: assert property (@(posedge clk) disable iff (rst)
        !found |=> (!iss_vld && iss_ctx == '0 && iss_pc == '0));
endmodule

// File: tb/ctx_issue_sel_tb_top.sv
module ctx_issue_sel_tb_top;
    localparam int N     = 16;
    localparam int PW    = 32;
    localparam int CW    = $clog2(N);
    localparam int LIMIT = 20000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*PW-1:0] rst_pc_vec;
    logic            wb_vld = 1'b0;
    logic [CW-1:0]   wb_ctx = '0;
    logic [PW-1:0]   wb_pc  = '0;
    logic            susp_vld = 1'b0;
    logic [CW-1:0]   susp_ctx = '0;
    logic            resm_vld = 1'b0;
    logic [CW-1:0]   resm_ctx = '0;
    logic            iss_vld;
    logic [CW-1:0]   iss_ctx;
    logic [PW-1:0]   iss_pc;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit model_chk = 1'b0;
    bit done = 1'b0;

    // reference model state
    bit            m_busy [N];
    bit            m_park [N];
    logic [PW-1:0] m_pc   [N];
    int            m_last;
    bit            e_vld;
    int            e_ctx;
    logic [PW-1:0] e_pc;

    always #4 clk = ~clk;  // 125 MHz

    ctx_issue_sel #(.NUM_CTX(N), .PC_W(PW)) dut_i (
        .clk(clk), .rst(rst), .rst_pc_vec(rst_pc_vec),
        .wb_vld(wb_vld), .wb_ctx(wb_ctx), .wb_pc(wb_pc),
        .susp_vld(susp_vld), .susp_ctx(susp_ctx),
        .resm_vld(resm_vld), .resm_ctx(resm_ctx),
        .iss_vld(iss_vld), .iss_ctx(iss_ctx), .iss_pc(iss_pc)
    );

    function automatic logic [PW-1:0] vec_pc(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h40;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) rst_pc_vec[i*PW +: PW] = vec_pc(i);
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model: same one-edge rule as the requirements
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_busy[i] = 1'b0;
                m_park[i] = 1'b0;
                m_pc[i]   = vec_pc(i);
            end
            m_last = N - 1;
            e_vld = 1'b0; e_ctx = 0; e_pc = '0;
        end else begin
            int pk;
            int c;
            pk = -1;
            for (int off = 1; off <= N; off++) begin
                c = (m_last + off) % N;
                if (pk < 0 && !m_busy[c] && !m_park[c]) pk = c;
            end
            if (wb_vld && m_busy[wb_ctx]) begin
                m_busy[wb_ctx] = 1'b0;
                m_pc[wb_ctx]   = wb_pc;
            end
            if (susp_vld) m_park[susp_ctx] = 1'b1;
            if (resm_vld) m_park[resm_ctx] = 1'b0;
            if (pk >= 0) begin
                e_vld = 1'b1; e_ctx = pk; e_pc = m_pc[pk];
                m_busy[pk] = 1'b1;
                m_last = pk;
            end else begin
                e_vld = 1'b0; e_ctx = 0; e_pc = '0;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (model_chk && !rst) begin
            chk("R3 iss_vld", 64'(iss_vld), 64'(e_vld));
            chk("R2 iss_ctx", 64'(iss_ctx), 64'(e_ctx));
            chk("R5 iss_pc", 64'(iss_pc), 64'(e_pc));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc >= LIMIT && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic clear_in();
        wb_vld = 1'b0; susp_vld = 1'b0; resm_vld = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 valid low in reset", 64'(iss_vld), 64'd0);
        rst = 1'b0;
        model_chk = 1'b1;

        // R1, R2: first round issues 0..N-1 with reset PCs
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            chk("R1 first round ctx", 64'(iss_ctx), 64'(k));
            chk("R1 first round pc", 64'(iss_pc), 64'(vec_pc(k)));
        end
        @(negedge clk);
        chk("R9 bubble when all busy", 64'({iss_vld, iss_pc}), 64'd0);

        // R5: writeback to in-flight ctx 2 releases it with the new PC
        wb_vld = 1'b1; wb_ctx = CW'(2); wb_pc = 32'h0000_00A0;
        @(negedge clk); clear_in();
        chk("R4 ctx2 not reissued yet", 64'(iss_vld), 64'd0);
        @(negedge clk);
        chk("R5 ctx2 reissued", 64'(iss_ctx), 64'd2);
        chk("R5 ctx2 new pc", 64'(iss_pc), 64'h0A0);

        // R7: writeback accepted while suspending the same context
        wb_vld = 1'b1; wb_ctx = CW'(2); wb_pc = 32'h0000_00B0;
        susp_vld = 1'b1; susp_ctx = CW'(2);
        @(negedge clk); clear_in();
        // R6: writeback to idle (parked) ctx 2 is ignored
        wb_vld = 1'b1; wb_ctx = CW'(2); wb_pc = 32'h0000_00C0;
        @(negedge clk); clear_in();
        chk("R7 parked ctx held out", 64'(iss_vld), 64'd0);
        // R8: simultaneous suspend and resume of ctx 2
        susp_vld = 1'b1; susp_ctx = CW'(2);
        resm_vld = 1'b1; resm_ctx = CW'(2);
        @(negedge clk); clear_in();
        chk("R8 still bubble before pick", 64'(iss_vld), 64'd0);
        @(negedge clk);
        chk("R8 resume wins ctx", 64'({iss_vld, 4'(iss_ctx)}), 64'h12);
        chk("R6 ignored writeback keeps pc", 64'(iss_pc), 64'h0B0);

        // Constrained random phase
        for (int t = 0; t < 4000; t++) begin
            int r;
            clear_in();
            r = int'($urandom_range(N - 1));
            if ($urandom_range(99) < 60 && (m_busy[r] || $urandom_range(99) < 20)) begin
                wb_vld = 1'b1; wb_ctx = CW'(r); wb_pc = $urandom();
            end
            if ($urandom_range(99) < 10) begin
                susp_vld = 1'b1; susp_ctx = CW'($urandom_range(N - 1));
            end
            if ($urandom_range(99) < 25) begin
                resm_vld = 1'b1; resm_ctx = CW'($urandom_range(N - 1));
            end
            @(negedge clk);
        end
        clear_in();
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule